// File: doc/BRIEF.md
# Multi-Port Line-Fetch Arbiter with Idle-Cycle Prefetch

This block sits between sixteen per-port caches and one wide shared memory. A port whose word access misses in its own cache raises a request together with the missing 20-bit word address. Each cycle the arbiter can launch one line access. It picks one requesting port with the priority scheme selected at run time: round-robin, LFSR-seeded pseudo-random, or a programmable slot table. It drops the five word-offset bits of the winner's address to get the 15-bit number of the 1024-bit memory line, and it holds the grant until the memory acknowledges. On the acknowledge cycle, the returned line is steered to the winning port.

A cycle with no outstanding miss is not left unused. The arbiter then starts a prefetch of the next line into the port cache that has the fewest unread words left and has not yet been prefilled. Each cache reports its remaining-word count, the line it is consuming and whether a prefill is already held, so the arbiter keeps no per-port cache state of its own.

Top module: `line_fetch_arbiter`

## Requirements
- R1: While rst_n is low, mem_req_o, grant_o, grant_pf_o and fill_valid_o are all zero.
- R2: Only ports with miss_req_i set compete for demand fetches. While mem_req_o is high, grant_o is one-hot and grant_o, grant_pf_o and mem_line_o stay stable until a cycle with mem_ack_i high. With no candidate at all, mem_req_o is low and grant_o is zero.
- R3: The line address of a demand fetch is bits [19:5] of the winner's word address (word address of port p is miss_addr_i[20p+19:20p]).
- R4: In a cycle with mem_req_o and mem_ack_i both high, fill_valid_o equals grant_o and fill_data_o equals mem_rdata_i. On that same clock edge a new choice is made, and the port just served is excluded from that choice.
- R5: With arb_mode_i = 0 (and also 3), the search starts at the port after the last demand winner and wraps around. After reset the last winner is port 15.
- R6: With arb_mode_i = 1, the search starts at the port given by bits [3:0] of a 16-bit LFSR. The LFSR is seeded to 0xACE1 in reset and shifts left every cycle after reset. Its new bit 0 is the XOR of bits 15, 13, 12 and 10.
- R7: With arb_mode_i = 2, the port held in the current table slot wins if it requests. Otherwise the R5 search applies. The slot pointer advances by one, modulo 16, on every demand grant made in this mode. Slot s resets to port s and is rewritten on a clock edge with tbl_wr_i high (slot tbl_slot_i, port tbl_port_i).
- R8: When no port is eligible for a demand fetch, a prefetch is granted with grant_pf_o high. It goes to the port with prefilled_i low and the smallest words_left_i (6 bits per port); among equal counts, the lowest port index wins. Its line is that port's cur_line_i (15 bits per port) plus one, modulo 2^15.
- R9: Whenever any eligible demand miss exists, no prefetch is granted.
- R10: Prefetch grants do not move the last-winner pointer used by R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arb_mode_i | input | 2 | Priority scheme: 0/3 round-robin, 1 pseudo-random, 2 table |
| tbl_wr_i | input | 1 | Slot table write strobe |
| tbl_slot_i | input | 4 | Slot table entry to write |
| tbl_port_i | input | 4 | Port number written into the slot |
| miss_req_i | input | 16 | Per-port demand miss request |
| miss_addr_i | input | 320 | Per-port missing word address, 20 bits each |
| words_left_i | input | 96 | Per-port unread words in the current line, 6 bits each |
| cur_line_i | input | 240 | Per-port line being consumed, 15 bits each |
| prefilled_i | input | 16 | Per-port flag: a prefetched line is already held |
| mem_req_o | output | 1 | Shared memory line access request |
| mem_line_o | output | 15 | Line number accessed |
| mem_ack_i | input | 1 | Memory has returned the line |
| mem_rdata_i | input | 1024 | Returned line data |
| grant_o | output | 16 | One-hot owner of the current access |
| grant_pf_o | output | 1 | Current access is a prefetch |
| fill_valid_o | output | 16 | One-hot fill strobe to the owning cache |
| fill_data_o | output | 1024 | Line delivered to the caches |

## Verification
On every cycle the assertions check the following: the grant is one-hot while a request is up and held until acknowledge; nothing is granted while idle; a fill strobe appears only with an acknowledge; a freshly started demand access belongs to a port that was requesting and carries that port's line number; and a freshly started prefetch starts only in a cycle with no pending miss. The order of winners under each priority scheme can only be shown by the bench's reference model over its scenarios. The same holds for the LFSR sequence, the table stepping and its fallback, the fewest-words prefetch choice with its tie-break and line wrap, and the pointer staying put across prefetches.

// File: rtl/lfa_pkg.sv
package lfa_pkg;
  typedef enum logic [1:0] {
    ARB_ROTATE = 2'd0,
    ARB_RANDOM = 2'd1,
    ARB_TABLE  = 2'd2,
    ARB_ROT_B  = 2'd3
  } arb_mode_e;

  localparam int LFSR_W     = 16;
  localparam logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1;
  localparam logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400;  // bits 15,13,12,10
endpackage

// File: rtl/lfa_lfsr.sv
module lfa_lfsr #(
  parameter int W = 16,
  parameter logic [W-1:0] SEED = '1,
  parameter logic [W-1:0] TAPS = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] state_o
);
  logic [W-1:0] state_q, state_d;

  always_comb begin
    state_d = {state_q[W-2:0], ^(state_q & TAPS)};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEED;
    else        state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/lfa_rot_pick.sv
module lfa_rot_pick #(
  parameter int N = 16,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req_i,
  input  logic [IDX_W-1:0] start_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int k = 0; k < N; k++) begin
      int j;
      j = (int'(start_i) + k) % N;
      if (!found_o && req_i[j]) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(j);
      end
    end
  end
endmodule

// File: rtl/lfa_pf_pick.sv
module lfa_pf_pick #(
  parameter int N     = 16,
  parameter int REM_W = 6,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]       cand_i,
  input  logic [N*REM_W-1:0] remain_i,
  output logic               found_o,
  output logic [IDX_W-1:0]   idx_o
);
  logic [REM_W-1:0] best;

  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    best    = '1;
    for (int i = 0; i < N; i++) begin
      if (cand_i[i] && (!found_o || remain_i[i*REM_W +: REM_W] < best)) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(i);
        best    = remain_i[i*REM_W +: REM_W];
      end
    end
  end
endmodule

// File: rtl/line_fetch_arbiter.sv
module line_fetch_arbiter
  import lfa_pkg::*;
#(
  parameter int N_PORTS    = 16,
  parameter int ADDR_W     = 20,
  parameter int WORD_W     = 32,
  parameter int LINE_WORDS = 32,
  localparam int IDX_W   = $clog2(N_PORTS),
  localparam int OFF_W   = $clog2(LINE_WORDS),
  localparam int LINE_AW = ADDR_W - OFF_W,
  localparam int LINE_W  = LINE_WORDS * WORD_W,
  localparam int REM_W   = $clog2(LINE_WORDS + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [1:0]                 arb_mode_i,
  input  logic                       tbl_wr_i,
  input  logic [IDX_W-1:0]           tbl_slot_i,
  input  logic [IDX_W-1:0]           tbl_port_i,
  input  logic [N_PORTS-1:0]         miss_req_i,
  input  logic [N_PORTS*ADDR_W-1:0]  miss_addr_i,
  input  logic [N_PORTS*REM_W-1:0]   words_left_i,
  input  logic [N_PORTS*LINE_AW-1:0] cur_line_i,
  input  logic [N_PORTS-1:0]         prefilled_i,
  output logic                       mem_req_o,
  output logic [LINE_AW-1:0]         mem_line_o,
  input  logic                       mem_ack_i,
  input  logic [LINE_W-1:0]          mem_rdata_i,
  output logic [N_PORTS-1:0]         grant_o,
  output logic                       grant_pf_o,
  output logic [N_PORTS-1:0]         fill_valid_o,
  output logic [LINE_W-1:0]          fill_data_o
);
  localparam logic [IDX_W-1:0]   LAST_IDX = IDX_W'(N_PORTS - 1);
  localparam logic [N_PORTS-1:0] ONE_HOT0 = {{(N_PORTS-1){1'b0}}, 1'b1};

  // state
  logic                 busy_q, busy_d;
  logic                 pf_q, pf_d;
  logic [N_PORTS-1:0]   grant_q, grant_d;
  logic [LINE_AW-1:0]   line_q, line_d;
  logic [IDX_W-1:0]     last_q, last_d;
  logic [IDX_W-1:0]     slot_q, slot_d;
  logic [IDX_W-1:0]     tbl_q [N_PORTS];
  logic [LFSR_W-1:0]    lfsr;

  // arbitration nets
  logic                 served, load;
  logic [N_PORTS-1:0]   done_mask, elig, cand;
  logic [IDX_W-1:0]     rr_start, rr_idx, rnd_idx, pf_idx, win_idx, slot_port;
  logic                 rr_found, rnd_found, pf_found, tbl_hit, demand_any;
  arb_mode_e            mode;

  assign mode      = arb_mode_e'(arb_mode_i);
  assign served    = busy_q & mem_ack_i;
  assign load      = ~busy_q | mem_ack_i;
  assign done_mask = served ? grant_q : '0;
  assign elig      = miss_req_i & ~done_mask;
  assign cand      = ~prefilled_i & ~done_mask;
  assign rr_start  = (last_q == LAST_IDX) ? '0 : last_q + 1'b1;
  assign slot_port = tbl_q[slot_q];
  assign tbl_hit   = elig[slot_port];

  lfa_lfsr #(.W(LFSR_W), .SEED(LFSR_SEED), .TAPS(LFSR_TAPS)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .state_o(lfsr)
  );

  lfa_rot_pick #(.N(N_PORTS)) u_rr_pick (
    .req_i(elig), .start_i(rr_start), .found_o(rr_found), .idx_o(rr_idx)
  );

  lfa_rot_pick #(.N(N_PORTS)) u_rnd_pick (
    .req_i(elig), .start_i(lfsr[IDX_W-1:0]), .found_o(rnd_found), .idx_o(rnd_idx)
  );

  lfa_pf_pick #(.N(N_PORTS), .REM_W(REM_W)) u_pf_pick (
    .cand_i(cand), .remain_i(words_left_i), .found_o(pf_found), .idx_o(pf_idx)
  );

  // winner mux per priority scheme
  always_comb begin
    demand_any = rr_found;
    unique case (mode)
      ARB_RANDOM: begin
        win_idx    = rnd_idx;
        demand_any = rnd_found;
      end
      ARB_TABLE:  win_idx = tbl_hit ? slot_port : rr_idx;
      default:    win_idx = rr_idx;
    endcase
  end

  // next state
  always_comb begin
    busy_d  = busy_q;
    pf_d    = pf_q;
    grant_d = grant_q;
    line_d  = line_q;
    last_d  = last_q;
    slot_d  = slot_q;
    if (load) begin
      if (demand_any) begin
        busy_d  = 1'b1;
        pf_d    = 1'b0;
        grant_d = ONE_HOT0 << win_idx;
        line_d  = miss_addr_i[win_idx*ADDR_W + OFF_W +: LINE_AW];
        last_d  = win_idx;
        if (mode == ARB_TABLE)
          slot_d = (slot_q == LAST_IDX) ? '0 : slot_q + 1'b1;
      end else if (pf_found) begin
        busy_d  = 1'b1;
        pf_d    = 1'b1;
        grant_d = ONE_HOT0 << pf_idx;
        line_d  = cur_line_i[pf_idx*LINE_AW +: LINE_AW] + 1'b1;
      end else begin
        busy_d  = 1'b0;
        pf_d    = 1'b0;
        grant_d = '0;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      pf_q    <= 1'b0;
      grant_q <= '0;
      line_q  <= '0;
      last_q  <= LAST_IDX;
      slot_q  <= '0;
    end else if (load) begin
      busy_q  <= busy_d;
      pf_q    <= pf_d;
      grant_q <= grant_d;
      line_q  <= line_d;
      last_q  <= last_d;
      slot_q  <= slot_d;
    end
  end

  // slot table, reset to identity order
  for (genvar g = 0; g < N_PORTS; g++) begin : g_tbl
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        tbl_q[g] <= IDX_W'(g);
      else if (tbl_wr_i && tbl_slot_i == IDX_W'(g))
        tbl_q[g] <= tbl_port_i;
    end
  end

  assign mem_req_o    = busy_q;
  assign mem_line_o   = line_q;
  assign grant_o      = grant_q;
  assign grant_pf_o   = pf_q;
  assign fill_valid_o = grant_q & {N_PORTS{served}};
  assign fill_data_o  = mem_rdata_i;
endmodule

// File: rtl/lfa_checker.sv
module lfa_checker #(
  parameter int N_PORTS = 16,
  parameter int ADDR_W  = 20,
  parameter int OFF_W   = 5,
  localparam int LINE_AW = ADDR_W - OFF_W
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [N_PORTS-1:0]        miss_req_i,
  input logic [N_PORTS*ADDR_W-1:0] miss_addr_i,
  input logic                      mem_req_o,
  input logic                      mem_ack_i,
  input logic [LINE_AW-1:0]        mem_line_o,
  input logic [N_PORTS-1:0]        grant_o,
  input logic                      grant_pf_o,
  input logic [N_PORTS-1:0]        fill_valid_o
);
  logic [N_PORTS-1:0]        req_q;
  logic [N_PORTS*ADDR_W-1:0] addr_q;
  logic [LINE_AW-1:0]        exp_line;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= '0;
      addr_q <= '0;
    end else begin
      req_q  <= miss_req_i;
      addr_q <= miss_addr_i;
    end
  end

  always_comb begin
    exp_line = '0;
    for (int i = 0; i < N_PORTS; i++)
      if (grant_o[i]) exp_line = addr_q[i*ADDR_W + OFF_W +: LINE_AW];
  end

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |-> (!mem_req_o && grant_o == '0 && fill_valid_o == '0));

  p_grant_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |-> $countones(grant_o) == 1);

  p_idle_no_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_req_o |-> (grant_o == '0 && !grant_pf_o));

  p_hold_until_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_ack_i) |=>
      (mem_req_o && $stable(grant_o) && $stable(grant_pf_o) && $stable(mem_line_o)));

  p_winner_requested_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(mem_req_o) && !grant_pf_o) |-> (grant_o & req_q) != '0);

  p_line_from_winner_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(mem_req_o) && !grant_pf_o) |-> mem_line_o == exp_line);

  p_fill_needs_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid_o != '0) |-> (mem_ack_i && mem_req_o));

  p_prefetch_when_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(mem_req_o) && grant_pf_o) |-> req_q == '0);
endmodule

bind line_fetch_arbiter lfa_checker #(
  .N_PORTS(N_PORTS), .ADDR_W(ADDR_W), .OFF_W(OFF_W)
) u_lfa_checker (
  .clk(clk), .rst_n(rst_n), .miss_req_i(miss_req_i), .miss_addr_i(miss_addr_i),
  .mem_req_o(mem_req_o), .mem_ack_i(mem_ack_i), .mem_line_o(mem_line_o),
  .grant_o(grant_o), .grant_pf_o(grant_pf_o), .fill_valid_o(fill_valid_o)
);

// File: tb/line_fetch_arbiter_tb_top.sv
module line_fetch_arbiter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 16;
  localparam int AW = 20;
  localparam int LAW = 15;
  localparam int RW = 6;
  localparam int LW = 1024;
  localparam int WATCHDOG = 150000;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [1:0]        arb_mode;
  logic              tbl_wr;
  logic [3:0]        tbl_slot, tbl_port;
  logic [NP-1:0]     miss_req, prefilled;
  logic [NP*AW-1:0]  miss_addr;
  logic [NP*RW-1:0]  words_left;
  logic [NP*LAW-1:0] cur_line;
  logic              mem_req, mem_ack, grant_pf;
  logic [LAW-1:0]    mem_line;
  logic [LW-1:0]     mem_rdata, fill_data;
  logic [NP-1:0]     grant, fill_valid;

  int addr_a [NP];
  int wl_a   [NP];
  int cl_a   [NP];

  always_comb begin
    for (int p = 0; p < NP; p++) begin
      miss_addr[p*AW +: AW]   = AW'(addr_a[p]);
      words_left[p*RW +: RW]  = RW'(wl_a[p]);
      cur_line[p*LAW +: LAW]  = LAW'(cl_a[p]);
    end
  end

  always #(CLK_PERIOD/2) clk = ~clk;

  line_fetch_arbiter dut_i (
    .clk(clk), .rst_n(rst_n), .arb_mode_i(arb_mode), .tbl_wr_i(tbl_wr),
    .tbl_slot_i(tbl_slot), .tbl_port_i(tbl_port), .miss_req_i(miss_req),
    .miss_addr_i(miss_addr), .words_left_i(words_left), .cur_line_i(cur_line),
    .prefilled_i(prefilled), .mem_req_o(mem_req), .mem_line_o(mem_line),
    .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata), .grant_o(grant),
    .grant_pf_o(grant_pf), .fill_valid_o(fill_valid), .fill_data_o(fill_data)
  );

  int n_chk = 0, n_fail = 0;
  int ack_delay = 0;
  string tag_over = "";

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  int m_busy, m_pf, m_g, m_line, m_last, m_slot, m_lfsr, m_age;
  int m_tbl [NP];
  int ev_port, ev_pf;

  function automatic int rot_first(input bit el [NP], input int start);
    for (int k = 0; k < NP; k++) if (el[(start + k) % NP]) return (start + k) % NP;
    return -1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_pf = 0; m_g = 0; m_line = 0; m_last = NP - 1; m_slot = 0;
      m_lfsr = 16'hACE1; m_age = 0; ev_port = -1; ev_pf = 0;
      for (int s = 0; s < NP; s++) m_tbl[s] = s;
    end else begin
      bit served;
      bit el [NP];
      int w, best, bi;
      served  = (m_busy != 0) && mem_ack;
      ev_port = served ? m_g : -1;
      ev_pf   = m_pf;
      for (int i = 0; i < NP; i++) el[i] = miss_req[i] && !(served && i == m_g);
      if (!m_busy || served) begin
        m_age = 0;
        if (arb_mode == 2'd1)      w = rot_first(el, m_lfsr & 15);
        else if (arb_mode == 2'd2) w = el[m_tbl[m_slot]] ? m_tbl[m_slot]
                                                         : rot_first(el, (m_last + 1) % NP);
        else                       w = rot_first(el, (m_last + 1) % NP);
        if (w >= 0) begin
          m_busy = 1; m_pf = 0; m_g = w; m_line = addr_a[w] >> 5; m_last = w;
          if (arb_mode == 2'd2) m_slot = (m_slot + 1) % NP;
        end else begin
          bi = -1; best = 0;
          for (int i = 0; i < NP; i++)
            if (!prefilled[i] && !(served && i == m_g) && (bi < 0 || wl_a[i] < best)) begin
              bi = i; best = wl_a[i];
            end
          if (bi >= 0) begin
            m_busy = 1; m_pf = 1; m_g = bi; m_line = (cl_a[bi] + 1) % 32768;
          end else begin
            m_busy = 0; m_pf = 0;
          end
        end
      end else m_age++;
      if (tbl_wr) m_tbl[tbl_slot] = tbl_port;
      m_lfsr = ((m_lfsr << 1) | (((m_lfsr >> 15) ^ (m_lfsr >> 13) ^ (m_lfsr >> 12)
               ^ (m_lfsr >> 10)) & 1)) & 16'hFFFF;
    end
  end

  function automatic string gtag();
    if (m_pf) return "R8";
    if (tag_over != "") return tag_over;
    if (arb_mode == 2'd1) return "R6";
    if (arb_mode == 2'd2) return "R7";
    return "R5";
  endfunction

  // one cycle: cache-side reaction, memory ack, then compare
  task automatic step(input int n);
    for (int c = 0; c < n; c++) begin
      logic [NP-1:0] eg, ef;
      @(negedge clk);
      if (ev_port >= 0) begin
        if (ev_pf) prefilled[ev_port] = 1'b1;
        else       miss_req[ev_port]  = 1'b0;
      end
      mem_ack   = (m_busy != 0) && (m_age >= ack_delay);
      mem_rdata = {32{32'hC0DE0000 + 32'(n_chk)}};
      #1;
      if (!rst_n) begin
        chk(!mem_req && grant == '0 && !grant_pf && fill_valid == '0, "R1",
            "reset outputs", {mem_req, grant_pf, grant}, 64'h0);
      end else begin
        eg = m_busy ? (NP'(1) << m_g) : '0;
        ef = (m_busy && mem_ack) ? eg : '0;
        chk(mem_req == (m_busy != 0), "R2", "mem_req", mem_req, m_busy);
        chk(grant == eg, gtag(), "grant", grant, eg);
        chk(grant_pf == (m_busy != 0 && m_pf != 0), "R9", "grant_pf", grant_pf, m_pf);
        if (m_busy)
          chk(mem_line == LAW'(m_line), m_pf ? "R8" : "R3", "line", mem_line, m_line);
        chk(fill_valid == ef, "R4", "fill_valid", fill_valid, ef);
        if (ef != '0)
          chk(fill_data == mem_rdata, "R4", "fill_data", fill_data[63:0], mem_rdata[63:0]);
      end
    end
  endtask

  task automatic set_addrs(input int seed);
    for (int p = 0; p < NP; p++)
      addr_a[p] = ((p * 7919 + seed * 104729) ^ (p << 13)) & 20'hFFFFF;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_fail++;
    $display("FAIL R2 watchdog: actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; arb_mode = 2'd0; tbl_wr = 1'b0; tbl_slot = '0; tbl_port = '0;
    miss_req = '0; prefilled = '1; mem_ack = 1'b0; mem_rdata = '0;
    for (int p = 0; p < NP; p++) begin wl_a[p] = 32; cl_a[p] = p * 100; end
    set_addrs(0);
    step(4);                                   // R1 during reset
    rst_n = 1'b1;
    step(3);                                   // R2 idle, nothing requested

    // R5 round-robin, all ports then a sparse pattern with slow memory
    set_addrs(1); miss_req = '1; step(40);
    ack_delay = 2; set_addrs(3); miss_req = 16'hA5C3; step(60);

    // R6 pseudo-random start
    arb_mode = 2'd1; ack_delay = 1; set_addrs(2); miss_req = '1; step(60);
    set_addrs(5); miss_req = 16'h0F0F; step(40);

    // R7 table order, then fallback when slot owners are idle
    for (int s = 0; s < NP; s++) begin
      tbl_wr = 1'b1; tbl_slot = 4'(s); tbl_port = 4'((s * 5 + 3) % NP); step(1);
    end
    tbl_wr = 1'b0; arb_mode = 2'd2; ack_delay = 0;
    set_addrs(7); miss_req = '1; step(40);
    miss_req = 16'h3333; step(40);

    // R8 prefetch: fewest words, ties to lowest port, line wrap on port 7
    arb_mode = 2'd0;
    for (int p = 0; p < NP; p++) begin wl_a[p] = (p * 5) % 7 + 1; cl_a[p] = p * 1000; end
    cl_a[7] = 32767;
    prefilled = '0; step(50);

    // R9 demand misses arriving with prefetch candidates available
    prefilled = '0; ack_delay = 1; set_addrs(9); miss_req = 16'h0101; step(60);

    // R10 a prefetch does not move the round-robin pointer
    tag_over = "R10"; ack_delay = 0;
    prefilled = 16'h7FFF; step(5);
    miss_req = 16'h8001; step(20);
    tag_over = "";

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule